// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block sits in front of a synchronous memory array and manages its low-power state. A sleep request arrives on a pin that is not related to the memory clock. The block brings the request into the clock domain and then steps the memory through a fixed entry phase into sleep. When the request is withdrawn, it steps back out through an exit phase and a short recovery window. The access strobes reach the array only while the block is fully awake, so no write can disturb the stored data while the memory sleeps or changes state.

The host must deselect the memory before it asks for sleep, and must keep the select line idle during the recovery window after wake-up. When either rule is broken, the block discards the access and raises a sticky error flag. The flag stays set until reset. Two status outputs report the state: `asleep` is high in the sleep state itself, and `ready` is high only when accesses are allowed through.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After a synchronous reset, `ready` is 1 and `asleep`, `recov_err` and `entry_err` are 0.
- R2: The sleep request passes through a two-flop synchronizer. Suppose the request is raised before clock edge 1 and held. Then `ready` is 0 from edge 3 on, and `asleep` is 1 from edge 5 on. The entry phase lasts two cycles.
- R3: Suppose the request is dropped before edge 1 while the block sleeps. Then `asleep` is 0 from edge 3 on. The exit phase covers edges 3 and 4, and the recovery window covers edges 5 and 6. `ready` returns to 1 after edge 7.
- R4: While `ready` is 0, `cs_gated` and `we_gated` are 0 whatever the values of `cs_in` and `we_in`.
- R5: While `ready` is 1, `cs_gated` equals `cs_in` and `we_gated` equals `cs_in & we_in`, with no added cycle.
- R6: When `cs_in` is 1 at a clock edge in the recovery window, the access is discarded. `recov_err` becomes 1 after that edge and stays 1 until reset.
- R7: When `cs_in` is 1 at a clock edge in the entry phase, the access is discarded. `entry_err` becomes 1 after that edge and stays 1 until reset.
- R8: When `cs_in` is 1 while the block is awake, asleep, or in the exit phase, neither error flag is set.
- R9: Suppose the request is dropped while the entry phase is still running. The block completes entry anyway, sleeps for one cycle, and then runs the full exit and recovery sequence. For a request held high from before edge 1 until just before edge 4, `asleep` is 1 only after edge 5, and `ready` is 1 again from edge 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request, asynchronous to `clk` |
| cs_in | input | 1 | Chip select from the host, active high |
| we_in | input | 1 | Write strobe from the host, active high |
| cs_gated | output | 1 | Chip select passed to the array |
| we_gated | output | 1 | Write strobe passed to the array |
| asleep | output | 1 | High while in the sleep state |
| ready | output | 1 | High when awake and out of recovery |
| recov_err | output | 1 | Sticky flag: select seen during recovery |
| entry_err | output | 1 | Sticky flag: select seen during sleep entry |

## Verification
The status outputs lag the request pin by a fixed count of edges: two synchronizer flops, then the state register, then the phase counters. `ready` falls at edge 3 and `asleep` rises at edge 5 on entry. On exit, `asleep` falls at edge 3 and `ready` returns at edge 7. The bench drives every input on the falling clock edge and then samples once per cycle. At each step it compares the outputs with a formula in the edge index, so every cycle of every transition is checked, not only the end state. The gated strobes are combinational and are checked one time unit after the drive. The error flags are registered and are checked after the next rising edge.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE = 3'd0,
        ST_ENTER = 3'd1,
        ST_SLEEP = 3'd2,
        ST_EXIT  = 3'd3,
        ST_RECOV = 3'd4
    } pwr_state_t;

    typedef struct packed {
        logic cs;
        logic we;
    } strobe_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_open(input pwr_state_t s);
        return s == ST_AWAKE;
    endfunction

endpackage

// File: rtl/pwr_req_sync.sv
module pwr_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    output pwr_state_t state
);
    localparam int LONGEST = max3(ENTRY_CYC, EXIT_CYC, RECOV_CYC);
    localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

    logic [CNT_W-1:0] cnt;
    logic             cnt_done;

    assign cnt_done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_AWAKE: if (req) begin
                    state <= ST_ENTER;
                    cnt   <= CNT_W'(ENTRY_CYC - 1);
                end
                ST_ENTER: if (cnt_done) state <= ST_SLEEP;
                          else          cnt   <= cnt - CNT_W'(1);
                ST_SLEEP: if (!req) begin
                    state <= ST_EXIT;
                    cnt   <= CNT_W'(EXIT_CYC - 1);
                end
                ST_EXIT: if (cnt_done) begin
                    state <= ST_RECOV;
                    cnt   <= CNT_W'(RECOV_CYC - 1);
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                ST_RECOV: if (cnt_done) state <= ST_AWAKE;
                          else          cnt   <= cnt - CNT_W'(1);
                default: begin
                    state <= ST_AWAKE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_state_t state,
    input  strobe_t    host,
    output strobe_t    array,
    output logic       recov_err,
    output logic       entry_err
);
    logic open_q;

    assign open_q   = is_open(state);
    assign array.cs = host.cs & open_q;
    assign array.we = host.cs & host.we & open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            recov_err <= 1'b0;
            entry_err <= 1'b0;
        end else begin
            if (host.cs && state == ST_RECOV) recov_err <= 1'b1;
            if (host.cs && state == ST_ENTER) entry_err <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic cs_in,
    input  logic we_in,
    output logic cs_gated,
    output logic we_gated,
    output logic asleep,
    output logic ready,
    output logic recov_err,
    output logic entry_err
);
    logic       req_s;
    pwr_state_t state;
    strobe_t    host_s;
    strobe_t    array_s;

    pwr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sleep_req),
        .q_sync  (req_s)
    );

    pwr_seq_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req   (req_s),
        .state (state)
    );

    assign host_s.cs = cs_in;
    assign host_s.we = we_in;

    pwr_access_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .host      (host_s),
        .array     (array_s),
        .recov_err (recov_err),
        .entry_err (entry_err)
    );

    assign cs_gated = array_s.cs;
    assign we_gated = array_s.we;
    assign asleep   = (state == ST_SLEEP);
    assign ready    = is_open(state);
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cs_in,
    input logic we_in,
    input logic cs_gated,
    input logic we_gated,
    input logic asleep,
    input logic ready,
    input logic recov_err,
    input logic entry_err
);
    // R4
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!cs_gated && !we_gated));

    // R5
    gate_open_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_gated == cs_in && we_gated == (cs_in && we_in)));

    // R6
    recov_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        recov_err |=> recov_err);

    // R7
    entry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        entry_err |=> entry_err);

    // R2
    sleep_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !ready);

    // R2
    sleep_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> !$past(ready));

    // R3
    wake_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (!asleep && !$past(asleep)));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (.*);

// File: tb/tb_pwr_sleep_ctrl.sv
module tb_pwr_sleep_ctrl;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst, sleep_req, cs_in, we_in;
    logic cs_gated, we_gated, asleep, ready, recov_err, entry_err;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwr_sleep_ctrl dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cs_in(cs_in), .we_in(we_in),
        .cs_gated(cs_gated), .we_gated(we_gated), .asleep(asleep), .ready(ready),
        .recov_err(recov_err), .entry_err(entry_err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; sleep_req = 1'b0; cs_in = 1'b0; we_in = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic go_to_sleep();
        sleep_req = 1'b1;
        for (int i = 0; i < 9; i++) tick();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 ready", ready, 1'b1);
        check("R1 asleep", asleep, 1'b0);
        check("R1 recov_err", recov_err, 1'b0);
        check("R1 entry_err", entry_err, 1'b0);

        // R5 awake gating, all strobe combinations; R8 no flag while awake
        for (int p = 0; p < 4; p++) begin
            cs_in = p[1]; we_in = p[0];
            #1;
            check("R5 cs_gated", cs_gated, p[1]);
            check("R5 we_gated", we_gated, p[1] & p[0]);
            tick();
        end
        cs_in = 1'b0; we_in = 1'b0;
        check("R8 awake recov_err", recov_err, 1'b0);
        check("R8 awake entry_err", entry_err, 1'b0);

        // R2 entry timing per edge
        sleep_req = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            tick();
            check("R2 ready", ready, (i < 3));
            check("R2 asleep", asleep, (i >= 5));
        end

        // R4 gating closed while asleep; R8 no flag while asleep
        for (int p = 0; p < 4; p++) begin
            cs_in = p[1]; we_in = p[0];
            #1;
            check("R4 cs_gated", cs_gated, 1'b0);
            check("R4 we_gated", we_gated, 1'b0);
            tick();
        end
        cs_in = 1'b0; we_in = 1'b0;
        check("R8 asleep recov_err", recov_err, 1'b0);
        check("R8 asleep entry_err", entry_err, 1'b0);

        // R3 exit timing per edge (cs idle, we toggling)
        sleep_req = 1'b0;
        for (int i = 1; i <= 9; i++) begin
            we_in = i[0];
            tick();
            check("R3 asleep", asleep, (i < 3));
            check("R3 ready", ready, (i >= 7));
        end
        we_in = 1'b0;

        // R6 select during recovery window
        go_to_sleep();
        sleep_req = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        cs_in = 1'b1; we_in = 1'b1;
        #1;
        check("R6 cs blocked", cs_gated, 1'b0);
        check("R6 we blocked", we_gated, 1'b0);
        tick();
        cs_in = 1'b0; we_in = 1'b0;
        check("R6 recov_err set", recov_err, 1'b1);
        for (int i = 0; i < 4; i++) tick();
        check("R6 recov_err sticky", recov_err, 1'b1);
        check("R6 entry_err clear", entry_err, 1'b0);
        do_reset();
        check("R1 recov_err cleared", recov_err, 1'b0);

        // R7 select during entry phase
        sleep_req = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        cs_in = 1'b1;
        #1;
        check("R7 cs blocked", cs_gated, 1'b0);
        tick();
        cs_in = 1'b0;
        check("R7 entry_err set", entry_err, 1'b1);
        for (int i = 0; i < 6; i++) tick();
        check("R7 entry_err sticky", entry_err, 1'b1);
        check("R7 recov_err clear", recov_err, 1'b0);
        do_reset();

        // R8 select during exit phase sets no flag
        go_to_sleep();
        sleep_req = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        cs_in = 1'b1;
        tick();
        cs_in = 1'b0;
        check("R8 exit recov_err", recov_err, 1'b0);
        check("R8 exit entry_err", entry_err, 1'b0);
        for (int i = 0; i < 5; i++) tick();
        check("R3 ready after exit", ready, 1'b1);

        // R9 request dropped during entry phase
        do_reset();
        sleep_req = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            if (i == 4) sleep_req = 1'b0;
            tick();
            check("R9 asleep", asleep, (i == 5));
            check("R9 ready", ready, (i < 3) || (i >= 10));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule